// File: doc/BRIEF.md
# Byte-wide PROM Configuration Serializer

This block is the master end of a serial configuration chain. It presents a 16-bit address to an external byte-wide read-only memory, latches one byte from it every eight configuration clocks, and moves the address one location up or down after each fetch. The fetched bytes are sent out one bit at a time on a single serial line. The next device in the daisy chain reads that line on its rising clock edges.

Fetches are made on the rising clock edge. The serial line changes only on falling edges, one and a half periods after the fetch that supplied the byte. This gives the downstream device a full half period of setup before the rising edge on which it samples. A start pulse begins a load. The load ends once a programmed number of bits has left the block. At that point the memory enables are released, the line returns high and a done flag rises.

Top module: `cfgl_prom_loader`

## Requirements
- R1: While `rst` is high at a rising edge, `done` goes low and `prom_ce_n`/`prom_oe_n` go high. `prom_addr` loads 0x0000 if `dir_down` is 0 or 0xFFFF if `dir_down` is 1. `sdout` goes high at the next falling edge.
- R2: A `start` pulse that is sampled while no load is running starts a load. It reloads the start address, which is 0x0000 for `dir_down`=0 and 0xFFFF for `dir_down`=1. It also clears `done` and drives `prom_ce_n` and `prom_oe_n` low. The first byte is captured at the next rising edge.
- R3: Each capture moves `prom_addr` by +1 when `dir_down` was 0 at start, or by -1 when it was 1. Captures occur once every 8 clock cycles.
- R4: Bytes are sent least significant bit first. Bit D0 appears on `sdout` at the second falling edge after the capturing rising edge. Counting rising edges from the one that accepted `start` as edge 0, stream bit i is valid at rising edge i+3.
- R5: D0 of each byte follows D7 of the previous byte on the next falling edge, with no gap.
- R6: After `total_bits` bits (`total_bits` ≥ 1), `done` is high after rising edge `total_bits`+2 and stays high until the next start. `sdout` is high from the falling edge after that and remains high.
- R7: `prom_ce_n` and `prom_oe_n` are always equal and go high when `done` rises. `prom_addr` then holds start ±(`total_bits`/8 + 1), using integer division, and does not move while the memory is disabled.
- R8: `sdout` changes only on falling clock edges. It is stable from each rising edge to the next falling edge.
- R9: A `start` pulse during a running load has no effect on the stream, the address or the end of the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a load when no load is running |
| dir_down | input | 1 | 0: address counts up, 1: counts down (sampled at reset/start) |
| total_bits | input | 20 | Number of serial bits to emit in the load (≥ 1) |
| prom_data | input | 8 | Byte read from the external memory |
| prom_addr | output | 16 | Address to the external memory |
| prom_ce_n | output | 1 | Memory chip enable, active low |
| prom_oe_n | output | 1 | Memory output enable, active low |
| sdout | output | 1 | Serial data to the next device in the chain |
| done | output | 1 | Load complete |

## Verification
The bench reads every stream bit at the rising edge where a downstream device would sample it. A design that shifts too early or too late, or sends MSB first, shows the wrong bit. A gap at byte seams, or a wrong fetch spacing, misaligns bit 8 and later bits. The bench also reads each bit a second time just before the falling edge. This catches an output that moves on the rising edge. Bit counts of 1, 9, 16 and 20 test the stop logic at and off byte boundaries: an off-by-one there shows as an early or late `done`, as a line that is not high afterwards, or as a wrong final address. Loads in both directions, a restart straight from done, and a start pulse in the middle of a load expose a wrong step sign, a stale start address, or a load that restarts when it should not.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 20;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ld_state_e;

    typedef struct packed {
        logic arm;   // start accepted this cycle
        logic cap;   // capture memory byte, step address
        logic load;  // move held byte into shifter
        logic pres;  // shifter bit 0 is a valid stream bit
        logic run;   // load in progress
        logic done;  // load finished
    } ld_ctl_t;

    function automatic logic [ADDR_W-1:0] first_addr(input logic down);
        return down ? {ADDR_W{1'b1}} : {ADDR_W{1'b0}};
    endfunction

endpackage

// File: rtl/cfgl_ctrl.sv
module cfgl_ctrl
    import cfgl_pkg::*;
#(
    parameter int DATA_BITS = DATA_W,
    parameter int COUNT_W   = CNT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [COUNT_W-1:0] total_bits,
    output ld_ctl_t            ctl
);
    localparam int PH_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DATA_BITS - 1);
    localparam logic [PH_W-1:0] PH_LOAD = PH_W'(1);

    ld_state_e          st;
    logic [PH_W-1:0]    phase;
    logic [COUNT_W-1:0] sent;
    logic               pres_q;
    logic               fin;
    logic               arm;

    assign arm = start && (st != ST_RUN);
    assign fin = (st == ST_RUN) && pres_q && (sent == total_bits);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            phase  <= '0;
            sent   <= '0;
            pres_q <= 1'b0;
        end else if (arm) begin
            st     <= ST_RUN;
            phase  <= '0;
            sent   <= '0;
            pres_q <= 1'b0;
        end else if (st == ST_RUN) begin
            phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
            if (fin) begin
                st     <= ST_DONE;
                pres_q <= 1'b0;
            end else if (pres_q || (phase == PH_LOAD)) begin
                pres_q <= 1'b1;
                sent   <= sent + 1'b1;
            end
        end
    end

    always_comb begin
        ctl.arm  = arm;
        ctl.run  = (st == ST_RUN);
        ctl.done = (st == ST_DONE);
        ctl.cap  = (st == ST_RUN) && (phase == '0) && !fin;
        ctl.load = (st == ST_RUN) && (phase == PH_LOAD);
        ctl.pres = pres_q;
    end

endmodule

// File: rtl/cfgl_addr_gen.sv
module cfgl_addr_gen
    import cfgl_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dir_down,
    input  logic          arm,
    input  logic          cap,
    output logic [AW-1:0] addr
);
    logic dir_q;

    always_ff @(posedge clk) begin
        if (rst || arm) begin
            dir_q <= dir_down;
            addr  <= dir_down ? {AW{1'b1}} : {AW{1'b0}};
        end else if (cap) begin
            addr <= dir_q ? addr - 1'b1 : addr + 1'b1;
        end
    end

endmodule

// File: rtl/cfgl_ser.sv
module cfgl_ser
    import cfgl_pkg::*;
#(
    parameter int DATA_BITS = DATA_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cap,
    input  logic                 load,
    input  logic                 pres,
    input  logic [DATA_BITS-1:0] din,
    output logic                 sdout
);
    logic [DATA_BITS-1:0] hold;
    logic [DATA_BITS-1:0] shreg;

    // Rising-edge side: capture, then hand over one cycle later.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold  <= '0;
            shreg <= '0;
        end else begin
            if (cap)
                hold <= din;
            if (load)
                shreg <= hold;
            else
                shreg <= shreg >> 1;
        end
    end

    // Falling-edge side: launch the current bit half a cycle later.
    always_ff @(negedge clk) begin
        if (rst)
            sdout <= 1'b1;
        else
            sdout <= pres ? shreg[0] : 1'b1;
    end

endmodule

// File: rtl/cfgl_prom_loader.sv
module cfgl_prom_loader
    import cfgl_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic          cclk,
    input  logic          rst,
    input  logic          start,
    input  logic          dir_down,
    input  logic [CW-1:0] total_bits,
    input  logic [DW-1:0] prom_data,
    output logic [AW-1:0] prom_addr,
    output logic          prom_ce_n,
    output logic          prom_oe_n,
    output logic          sdout,
    output logic          done
);
    ld_ctl_t ctl;

    cfgl_ctrl #(.DATA_BITS(DW), .COUNT_W(CW)) u_ctrl (
        .clk        (cclk),
        .rst        (rst),
        .start      (start),
        .total_bits (total_bits),
        .ctl        (ctl)
    );

    cfgl_addr_gen #(.AW(AW)) u_addr (
        .clk      (cclk),
        .rst      (rst),
        .dir_down (dir_down),
        .arm      (ctl.arm),
        .cap      (ctl.cap),
        .addr     (prom_addr)
    );

    cfgl_ser #(.DATA_BITS(DW)) u_ser (
        .clk   (cclk),
        .rst   (rst),
        .cap   (ctl.cap),
        .load  (ctl.load),
        .pres  (ctl.pres),
        .din   (prom_data),
        .sdout (sdout)
    );

    assign prom_ce_n = !ctl.run;
    assign prom_oe_n = !ctl.run;
    assign done      = ctl.done;

endmodule

// File: rtl/cfgl_chk.sv
module cfgl_chk #(
    parameter int AW = 16
) (
    input logic          cclk,
    input logic          rst,
    input logic          start,
    input logic [AW-1:0] prom_addr,
    input logic          prom_ce_n,
    input logic          prom_oe_n,
    input logic          sdout,
    input logic          done
);
    // R1
    reset_state_chk: assert property (@(posedge cclk)
        rst |=> (!done && prom_ce_n && prom_oe_n));

    // R7
    enables_match_chk: assert property (@(posedge cclk) disable iff (rst)
        prom_ce_n == prom_oe_n);

    // R3
    addr_step_chk: assert property (@(posedge cclk) disable iff (rst)
        (!prom_ce_n && $past(!prom_ce_n)) |->
        (prom_addr == $past(prom_addr) ||
         prom_addr == $past(prom_addr) + 1'b1 ||
         prom_addr == $past(prom_addr) - 1'b1));

    // R7
    addr_hold_chk: assert property (@(posedge cclk) disable iff (rst)
        (prom_ce_n && $past(prom_ce_n) && !$past(start) && !$past(rst)) |->
        $stable(prom_addr));

    // R6
    line_idle_chk: assert property (@(posedge cclk) disable iff (rst)
        (done && $past(done)) |-> sdout);

    // R6
    done_sticky_chk: assert property (@(posedge cclk) disable iff (rst)
        (done && !start) |=> done);

    // R7
    done_release_chk: assert property (@(posedge cclk) disable iff (rst)
        done |-> prom_ce_n);

endmodule

bind cfgl_prom_loader cfgl_chk #(.AW(AW)) u_chk (
    .cclk      (cclk),
    .rst       (rst),
    .start     (start),
    .prom_addr (prom_addr),
    .prom_ce_n (prom_ce_n),
    .prom_oe_n (prom_oe_n),
    .sdout     (sdout),
    .done      (done)
);

// File: tb/tb_cfgl_prom_loader.sv
`timescale 1ns/1ps
module tb_cfgl_prom_loader;

    logic        cclk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        dir_down = 1'b0;
    logic [19:0] total_bits = 20'd8;
    logic [7:0]  prom_data;
    logic [15:0] prom_addr;
    logic        prom_ce_n, prom_oe_n, sdout, done;

    int n_checks = 0;
    int n_errors = 0;

    always #2 cclk = ~cclk;   // 250 MHz

    function automatic logic [7:0] rom_byte(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5 ^ {a[2:0], 5'b0};
    endfunction

    assign prom_data = (!prom_ce_n && !prom_oe_n) ? rom_byte(prom_addr) : 8'hFF;

    cfgl_prom_loader dut (
        .cclk       (cclk),
        .rst        (rst),
        .start      (start),
        .dir_down   (dir_down),
        .total_bits (total_bits),
        .prom_data  (prom_data),
        .prom_addr  (prom_addr),
        .prom_ce_n  (prom_ce_n),
        .prom_oe_n  (prom_oe_n),
        .sdout      (sdout),
        .done       (done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic t_reset(input logic dir);
        @(posedge cclk); #1;
        rst = 1'b1; dir_down = dir;
        @(posedge cclk); #1;
        @(posedge cclk); #1;
        // R1: reset state
        check(prom_addr == (dir ? 16'hFFFF : 16'h0000), "R1", "reset addr",
              prom_addr, dir ? 16'hFFFF : 16'h0000);
        check(sdout == 1'b1, "R1", "reset sdout", sdout, 1);
        check(done == 1'b0, "R1", "reset done", done, 0);
        check(prom_ce_n && prom_oe_n, "R1", "reset enables",
              {prom_ce_n, prom_oe_n}, 2'b11);
        rst = 1'b0;
    endtask

    // One full load; bit i is sampled at rising edge i+3 after the start edge.
    task automatic t_load(input logic dir, input int nbits, input bit mid_start);
        logic [15:0] base;
        logic [15:0] fin_addr;
        base = dir ? 16'hFFFF : 16'h0000;
        fin_addr = dir ? base - 16'(nbits / 8 + 1) : base + 16'(nbits / 8 + 1);
        @(posedge cclk); #1;
        dir_down = dir; total_bits = 20'(nbits); start = 1'b1;
        @(posedge cclk); #1;
        start = 1'b0;
        for (int k = 1; k <= nbits + 3; k++) begin
            @(posedge cclk); #1;
            if (mid_start && k == 10) start = 1'b1;   // R9: ignored mid-load
            if (mid_start && k == 11) start = 1'b0;
            if (k == 1) begin
                // R2: enables active once the load runs
                check(!prom_ce_n && !prom_oe_n, "R2", "enables low",
                      {prom_ce_n, prom_oe_n}, 2'b00);
                check(!done, "R2", "done cleared", done, 0);
            end
            if (k == 9) begin
                // R3: two captures so far
                check(prom_addr == (dir ? base - 16'd2 : base + 16'd2), "R3",
                      "addr after two fetches", prom_addr,
                      dir ? base - 16'd2 : base + 16'd2);
            end
            if (k >= 3 && k <= nbits + 2) begin
                int i;
                logic [15:0] ba;
                logic expb;
                i = k - 3;
                ba = dir ? base - 16'(i / 8) : base + 16'(i / 8);
                expb = rom_byte(ba)[i % 8];
                // R4 R5: LSB first, gapless across bytes
                check(sdout == expb, (i >= 8) ? "R5" : "R4", "stream bit",
                      sdout, expb);
                #0.8;
                // R8: no change before the falling edge
                check(sdout == expb, "R8", "stable until falling edge", sdout, expb);
            end
            if (k == nbits + 1)
                check(!done, "R6", "done not early", done, 0);
            if (k == nbits + 2) begin
                check(done, "R6", "done raised", done, 1);
                check(prom_ce_n && prom_oe_n, "R7", "enables released",
                      {prom_ce_n, prom_oe_n}, 2'b11);
                check(prom_addr == fin_addr, "R7", "final addr", prom_addr, fin_addr);
            end
            if (k == nbits + 3)
                check(sdout == 1'b1, "R6", "line idle high", sdout, 1);
        end
        repeat (3) @(posedge cclk);
        #1;
        check(done && sdout, "R6", "done and idle held", {done, sdout}, 2'b11);
        check(prom_addr == fin_addr, "R7", "addr held", prom_addr, fin_addr);
    endtask

    initial begin : watchdog
        #400000;
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        t_reset(1'b0);
        t_load(1'b0, 20, 1'b1);
        t_load(1'b1, 16, 1'b0);
        t_load(1'b0, 1, 1'b0);
        t_load(1'b0, 9, 1'b0);
        t_reset(1'b1);
        t_load(1'b1, 24, 1'b1);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule